// File: doc/BRIEF.md
# Auto/Manual Step Clock Controller

This block decides when a small accumulator computer may advance by one step. It works entirely inside one fast system clock domain. Its output is a single-cycle enable pulse that the rest of the machine treats as its clock edge. The block never creates a real clock edge. In automatic mode, the pulses come from an internal divider that runs freely with a fixed period. In manual mode, each press of a pushbutton gives exactly one pulse, once the press has been synchronised and debounced.

A toggle input flips the block between the two modes. The flip is applied only on a divider tick, so no pulse is ever split or doubled at the switch-over. A halt request stops the pulses in either mode, and they stay stopped until the next synchronous clear. The clear also returns the block to manual mode.

Top module: `clk_mode_ctrl`

## Requirements
- R1: While `rst_i` is high and after it falls, `manual_o` reads 1 (manual mode) and `step_en_o` stays 0 until a step source fires.
- R2: Each rising edge of `mode_tog_i` (seen after a two-flop synchroniser) requests one mode flip. Holding the input high gives only one flip. `manual_o` is 1 in manual mode and 0 in automatic mode.
- R3: The mode changes only in the cycle after a divider tick. Several requests between two ticks merge into one flip. On a flip from automatic to manual, the last automatic pulse appears in the same cycle as the new mode. On a flip to automatic, the first pulse comes exactly `TICK_PERIOD` cycles after the new mode appears.
- R4: In automatic mode, `step_en_o` pulses for one cycle every `TICK_PERIOD` system clocks.
- R5: In manual mode, an accepted press gives exactly one one-cycle pulse. Holding the button gives no further pulses, and releasing it gives none.
- R6: The debounced button level changes only after `DEB_CYCLES` consecutive synchronised samples differ from the accepted level. A shorter excursion, such as a glitch of `DEB_CYCLES-1` cycles or contact bounce, is ignored.
- R7: Presses add no pulses in automatic mode, and divider ticks add no pulses in manual mode.
- R8: Once `halt_i` has been high for any cycle, `step_en_o` stays 0 in both modes until `rst_i`. Mode toggling still works while halted.
- R9: `rst_i` clears the halt, so presses give pulses again after the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high clear |
| step_btn_i | input | 1 | Raw, bouncing step pushbutton (1 = pressed) |
| mode_tog_i | input | 1 | Mode toggle request, rising-edge sensitive |
| halt_i | input | 1 | Halt request, sticky until clear |
| step_en_o | output | 1 | One-cycle step enable pulse |
| manual_o | output | 1 | Current mode, 1 = manual, 0 = automatic |

## Verification
The bench builds the block with `TICK_PERIOD` = 6 and `DEB_CYCLES` = 4. With these values, whole windows of several automatic periods fit into a few dozen cycles. The debounce boundary also becomes cheap to test: a three-cycle glitch is rejected and a four-cycle run is accepted. The short period lets the bench measure exactly how a mode flip lines up with the tick, in both directions, and show that a halted block stays silent across many periods in both modes.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;

  typedef enum logic {
    MODE_AUTO   = 1'b0,
    MODE_MANUAL = 1'b1
  } run_mode_e;

  // mode after an optional flip
  function automatic run_mode_e next_mode(input run_mode_e cur, input logic flip);
    if (!flip) return cur;
    return (cur == MODE_AUTO) ? MODE_MANUAL : MODE_AUTO;
  endfunction

  // which event is allowed to produce a step in the given mode
  function automatic logic pick_source(input run_mode_e m, input logic tick, input logic press);
    return (m == MODE_AUTO) ? tick : press;
  endfunction

  // a step is passed on only when no halt is seen or remembered
  function automatic logic gate_step(input logic src, input logic halt_now, input logic halt_mem);
    return src & ~halt_now & ~halt_mem;
  endfunction

endpackage

// File: rtl/cmc_sync.sv
module cmc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] stage_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i) begin
        if (rst_i) stage_q[i] <= 1'b0;
        else       stage_q[i] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i) begin
        if (rst_i) stage_q[i] <= 1'b0;
        else       stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/cmc_tick_div.sv
module cmc_tick_div #(
  parameter int unsigned PERIOD = 8
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic tick_o
);

  localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i) begin
    if (rst_i)       cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end

  // ticks are isolated single-cycle events
  assert_tick_gap_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    tick_o |=> !tick_o);

endmodule

// File: rtl/cmc_debounce.sv
module cmc_debounce #(
  parameter int unsigned STABLE = 16
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic raw_i,
  output logic level_o,
  output logic press_o
);

  localparam int unsigned CW = (STABLE > 1) ? $clog2(STABLE) : 1;
  localparam logic [CW-1:0] LAST = CW'(STABLE - 1);

  logic          sync_w;
  logic          level_q;
  logic          press_q;
  logic [CW-1:0] run_q;
  logic          differs_w;
  logic          accept_w;

  cmc_sync #(.STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (raw_i),
    .q_o   (sync_w)
  );

  assign differs_w = (sync_w != level_q);
  assign accept_w  = differs_w && (run_q == LAST);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      level_q <= 1'b0;
      press_q <= 1'b0;
      run_q   <= '0;
    end else begin
      press_q <= accept_w & sync_w;
      if (!differs_w) begin
        run_q <= '0;
      end else if (accept_w) begin
        level_q <= sync_w;
        run_q   <= '0;
      end else begin
        run_q <= run_q + CW'(1);
      end
    end
  end

  assign level_o = level_q;
  assign press_o = press_q;

  // a press lasts exactly one cycle
  assert_press_single_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    press_o |=> !press_o);

  // every accepted rising level produces a press event
  assert_press_on_rise_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(level_o) |-> press_o);

  // a level change needs a full run of differing samples
  assert_level_after_run_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(level_o) |-> ($past(run_q) == LAST));

endmodule

// File: rtl/cmc_mode_latch.sv
module cmc_mode_latch
  import clkmode_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_i,
  input  logic      tog_i,
  input  logic      tick_i,
  output run_mode_e mode_o,
  output logic      flip_o
);

  logic      tog_s_w;
  logic      tog_prev_q;
  logic      tog_edge_w;
  logic      pending_q;
  logic      want_w;
  run_mode_e mode_q;

  cmc_sync #(.STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (tog_i),
    .q_o   (tog_s_w)
  );

  assign tog_edge_w = tog_s_w & ~tog_prev_q;
  assign want_w     = pending_q | tog_edge_w;
  assign flip_o     = want_w & tick_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      tog_prev_q <= 1'b0;
      pending_q  <= 1'b0;
      mode_q     <= MODE_MANUAL;
    end else begin
      tog_prev_q <= tog_s_w;
      pending_q  <= want_w & ~tick_i;
      mode_q     <= next_mode(mode_q, flip_o);
    end
  end

  assign mode_o = mode_q;

  // mode only moves right after a tick
  assert_flip_on_tick_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(mode_q) |-> $past(tick_i));

  // mode only moves when a toggle was requested
  assert_flip_needs_req_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(mode_q) |-> $past(pending_q | tog_edge_w));

endmodule

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
  import clkmode_pkg::*;
#(
  parameter int unsigned TICK_PERIOD = 8,
  parameter int unsigned DEB_CYCLES  = 16
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic step_btn_i,
  input  logic mode_tog_i,
  input  logic halt_i,
  output logic step_en_o,
  output logic manual_o
);

  logic      tick_w;
  logic      press_w;
  logic      level_w;
  logic      flip_w;
  run_mode_e mode_w;
  logic      src_w;
  logic      halted_q;
  logic      en_q;

  cmc_tick_div #(.PERIOD(TICK_PERIOD)) u_div (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .tick_o (tick_w)
  );

  cmc_debounce #(.STABLE(DEB_CYCLES)) u_deb (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .raw_i   (step_btn_i),
    .level_o (level_w),
    .press_o (press_w)
  );

  cmc_mode_latch u_mode (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .tog_i  (mode_tog_i),
    .tick_i (tick_w),
    .mode_o (mode_w),
    .flip_o (flip_w)
  );

  assign src_w = pick_source(mode_w, tick_w, press_w);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      halted_q <= 1'b0;
      en_q     <= 1'b0;
    end else begin
      halted_q <= halted_q | halt_i;
      en_q     <= gate_step(src_w, halt_i, halted_q);
    end
  end

  assign step_en_o = en_q;
  assign manual_o  = (mode_w == MODE_MANUAL);

  // clear forces manual mode and a quiet output
  assert_reset_state_R1: assert property (@(posedge clk_i)
    rst_i |=> (manual_o && !step_en_o));

  // enable pulses are one cycle wide
  assert_pulse_single_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    step_en_o |=> !step_en_o);

  // a remembered halt silences the output
  assert_halt_blocks_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    halted_q |=> !step_en_o);

  // halt stays until the clear
  assert_halt_sticky_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    halted_q |=> halted_q);

  // in manual mode a pulse needs a press one cycle before
  assert_manual_needs_press_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (step_en_o && $past(mode_w == MODE_MANUAL)) |-> $past(press_w));

endmodule

// File: tb/clk_mode_ctrl_tb.sv
module clk_mode_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TB_PERIOD  = 6;
  localparam int TB_DEB     = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn = 1'b0;
  logic tog = 1'b0;
  logic halt = 1'b0;
  logic en;
  logic manual;

  int total = 0;
  int failed = 0;
  int pulse_cnt = 0;
  int chg_cnt = 0;
  int en_at_chg = 0;
  bit finished = 1'b0;

  typedef struct {
    int    exp;
    string tag;
  } item_t;
  item_t sb_q[$];

  clk_mode_ctrl #(.TICK_PERIOD(TB_PERIOD), .DEB_CYCLES(TB_DEB)) u_dut (
    .clk_i      (clk),
    .rst_i      (rst),
    .step_btn_i (btn),
    .mode_tog_i (tog),
    .halt_i     (halt),
    .step_en_o  (en),
    .manual_o   (manual)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: counts enable pulses away from the active edge
  always @(negedge clk) if (en) pulse_cnt++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  // driver side: expected pulse count for the coming window
  task automatic open_win(input int exp, input string tag);
    item_t it;
    it.exp = exp;
    it.tag = tag;
    sb_q.push_back(it);
    pulse_cnt = 0;
  endtask

  task automatic close_win();
    item_t it;
    it = sb_q.pop_front();
    check(pulse_cnt == it.exp, it.tag, pulse_cnt, it.exp);
  endtask

  task automatic press(input int hold);
    btn = 1'b1;
    cyc(hold);
    btn = 1'b0;
    cyc(hold);
  endtask

  task automatic pulse_tog();
    tog = 1'b1;
    cyc(1);
    tog = 1'b0;
  endtask

  task automatic watch(input int n);
    logic prev;
    prev = manual;
    for (int i = 0; i < n; i++) begin
      cyc(1);
      if (manual != prev) begin
        chg_cnt++;
        en_at_chg = int'(en);
        prev = manual;
      end
    end
  endtask

  task automatic wait_flip(input int limit);
    logic prev;
    int w;
    prev = manual;
    w = 0;
    while (manual == prev && w < limit) begin
      cyc(1);
      w++;
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - failed, total);
  endtask

  initial begin
    int k;
    int bounce_on[10];
    int bounce_off[6];
    bounce_on  = '{1, 0, 1, 1, 0, 1, 0, 0, 1, 0};
    bounce_off = '{0, 1, 0, 1, 1, 0};

    cyc(3);
    rst = 1'b0;
    cyc(1);
    check(manual == 1'b1, "R1 manual after clear", int'(manual), 1);
    check(en == 1'b0, "R1 enable low after clear", int'(en), 0);

    open_win(0, "R7 ticks ignored in manual");
    cyc(40);
    close_win();

    open_win(1, "R5 single press one pulse");
    press(12);
    close_win();

    open_win(1, "R5 long hold no repeat");
    press(60);
    close_win();

    open_win(0, "R6 glitch of DEB-1 rejected");
    btn = 1'b1;
    cyc(TB_DEB - 1);
    btn = 1'b0;
    cyc(20);
    close_win();

    open_win(1, "R6 run of DEB accepted");
    btn = 1'b1;
    cyc(TB_DEB);
    btn = 1'b0;
    cyc(20);
    close_win();

    open_win(1, "R6 bouncing press one pulse");
    foreach (bounce_on[i]) begin
      btn = bounce_on[i][0];
      cyc(1);
    end
    btn = 1'b1;
    cyc(20);
    foreach (bounce_off[i]) begin
      btn = bounce_off[i][0];
      cyc(1);
    end
    btn = 1'b0;
    cyc(20);
    close_win();

    // switch to automatic
    pulse_tog();
    wait_flip(3 * TB_PERIOD + 6);
    check(manual == 1'b0, "R2 toggle enters auto", int'(manual), 0);
    check(en == 1'b0, "R3 no pulse on flip to auto", int'(en), 0);
    k = 0;
    do begin cyc(1); k++; end while (!en && k < 100);
    check(k == TB_PERIOD, "R3 first auto pulse one period after flip", k, TB_PERIOD);
    k = 0;
    do begin cyc(1); k++; end while (!en && k < 100);
    check(k == TB_PERIOD, "R4 auto pulse spacing", k, TB_PERIOD);

    open_win(5, "R4 auto rate five periods");
    cyc(5 * TB_PERIOD);
    close_win();

    open_win(5, "R7 press ignored in auto");
    btn = 1'b1;
    cyc(10);
    btn = 1'b0;
    cyc(5 * TB_PERIOD - 10);
    close_win();

    // held toggle: one flip back to manual
    chg_cnt = 0;
    en_at_chg = 0;
    tog = 1'b1;
    watch(4 * TB_PERIOD);
    tog = 1'b0;
    watch(2 * TB_PERIOD);
    check(chg_cnt == 1, "R2 held toggle flips once", chg_cnt, 1);
    check(manual == 1'b1, "R2 back in manual", int'(manual), 1);
    check(en_at_chg == 1, "R3 last auto pulse with flip", en_at_chg, 1);

    open_win(1, "R5 press after return to manual");
    press(12);
    close_win();

    // halt in automatic mode
    pulse_tog();
    wait_flip(3 * TB_PERIOD + 6);
    check(manual == 1'b0, "R2 toggle enters auto again", int'(manual), 0);
    halt = 1'b1;
    cyc(1);
    halt = 1'b0;
    open_win(0, "R8 halted in auto");
    cyc(5 * TB_PERIOD);
    close_win();

    pulse_tog();
    wait_flip(3 * TB_PERIOD + 6);
    check(manual == 1'b1, "R8 toggle works while halted", int'(manual), 1);
    open_win(0, "R8 halted in manual");
    press(12);
    close_win();

    // clear releases the halt
    rst = 1'b1;
    cyc(2);
    rst = 1'b0;
    cyc(1);
    check(manual == 1'b1, "R9 manual after second clear", int'(manual), 1);
    check(en == 1'b0, "R9 enable low after second clear", int'(en), 0);
    open_win(1, "R9 press works after clear");
    press(12);
    close_win();

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      total++;
      failed++;
      $display("FAIL watchdog R1..all actual=0 expected=1");
      summary();
      $finish;
    end
  end

endmodule